// File: doc/BRIEF.md
# Indirect Flash Read Sequencer

This block performs one programmed read from a serial flash device and streams the returned bytes into a local receive FIFO. Software first loads a read instruction word, a mode byte, an address-size field, a start address and a byte count. It then sets the start bit of the control register. The sequencer keeps chip select low for the whole transfer and produces one flash clock enable per system cycle. The pin-level clock generator turns each enable into an SCLK edge pair. The opcode and the address always go out on DQ0. An optional mode byte follows on DQ0. Dummy clocks follow with every lane released. Data is then captured on one, two or four lanes. A reader on the bus side pops bytes from the FIFO through a show-ahead port. The FIFO depth must be a power of two.

The control state machine has six states. IDLE goes to CMD on an accepted start. CMD goes to ADDR after 8 clocks. ADDR goes to MODE when mode is enabled. Otherwise ADDR goes to DUMMY when the dummy count is non-zero, and to DATA when it is zero. MODE goes to DUMMY or DATA by the same rule. DUMMY goes to DATA once the count has run out. DATA goes back to IDLE after the last byte is pushed. Cancel forces any state back to IDLE. While the FIFO is full, DATA holds its position and produces no clocks.

Top module: `qrd_top`

## Requirements
- R1: After reset the control register reads 0 and the level register reads 0. Chip select is high, no clock enable is issued, and no DQ output is enabled.
- R2: Register map by index. 0 holds the read instruction word, 1 the mode byte (bits 7:0), 2 the address size (bits 3:0), 3 the start address, 4 the byte count, 5 the control word and 6 the FIFO level. Instruction word fields: opcode in bits 7:0, command lane type in bits 9:8, address lane type in bits 13:12, data lane type in bits 17:16, mode enable in bit 20, dummy clocks in bits 28:24. All other bits read back as 0.
- R3: An accepted start first sends the opcode on DQ0, MSB first, over 8 clocks. Only DQ0 is output-enabled during this phase, whatever the command and address lane fields hold.
- R4: The address is sent next on DQ0, MSB first. It takes size[1:0]+1 bytes (2 gives 3 bytes, 3 gives 4 bytes) from the low end of the start address.
- R5: When mode is enabled, the mode byte follows on DQ0 over 8 clocks. Then the programmed number of dummy clocks follows, and 0 skips that phase. During dummy and data clocks no DQ output is enabled.
- R6: Data lane type 0 (single) captures DQ1, type 1 (dual) captures DQ1:0 and type 2 (quad) captures DQ3:0, MSB first. Type 3 behaves as single. Each completed byte is pushed into the FIFO in arrival order.
- R7: Writing control bit 0 starts a transfer only when idle and only with a non-zero byte count. The count is latched at start. A start accepted this way sets the in-progress bit (bit 2) and clears done (bit 5). A start while busy has no effect.
- R8: Done is set in the same cycle that in-progress clears, right after the last byte is pushed. Writing 1 to bit 5 clears done.
- R9: While the FIFO is full during the data phase no clock enable is issued and no byte is lost. Clocking resumes once a byte is popped.
- R10: Writing control bit 1 returns the sequencer to idle with chip select high. In-progress clears, done is not set and the FIFO is emptied. Cancel wins over a start in the same write.
- R11: Level register bits 15:0 give the FIFO occupancy. A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fifo_pop | input | 1 | Pop the head byte of the FIFO |
| fifo_data | output | 8 | Head byte of the FIFO |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sclk_en | output | 1 | One flash clock in this cycle |
| fl_dq_out | output | 4 | Flash DQ output values |
| fl_dq_oe | output | 4 | Flash DQ output enables |
| fl_dq_in | input | 4 | Flash DQ input values, sampled in clocked data cycles |

## Verification
The assertions rely on the configuration registers holding steady while a transfer is in progress. The only configuration write allowed during a transfer is to the byte count, which is already latched. The assertions also rely on the flash presenting its data bits in the cycle whose clock enable captures them. The stimulus never rewrites the instruction, mode, size or address registers until in-progress has cleared or a cancel has been issued. The bench's flash model drives DQ at the falling edge that precedes each clocked data cycle, with random values on unused lanes.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_ADDR, S_MODE, S_DUMMY, S_DATA
    } seq_state_e;

    localparam logic [2:0] RIDX_INSTR = 3'd0;
    localparam logic [2:0] RIDX_MODEB = 3'd1;
    localparam logic [2:0] RIDX_ASIZE = 3'd2;
    localparam logic [2:0] RIDX_SADDR = 3'd3;
    localparam logic [2:0] RIDX_COUNT = 3'd4;
    localparam logic [2:0] RIDX_CTRL  = 3'd5;
    localparam logic [2:0] RIDX_LEVEL = 3'd6;

    localparam logic [1:0] LANE_DUAL = 2'd1;
    localparam logic [1:0] LANE_QUAD = 2'd2;

    localparam logic [31:0] INSTR_MASK = 32'h1F13_33FF;
endpackage

// File: rtl/qrd_regs.sv
module qrd_regs
    import qrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] instr_q,
    output logic [7:0]  mode_byte,
    output logic [3:0]  addr_size,
    output logic [31:0] start_addr,
    output logic [31:0] byte_count,
    output logic        start_p,
    output logic        cancel_p,
    output logic        done_clr_p
);
    logic ctrl_wr;
    assign ctrl_wr    = reg_wr && (reg_addr == RIDX_CTRL);
    assign start_p    = ctrl_wr && reg_wdata[0];
    assign cancel_p   = ctrl_wr && reg_wdata[1];
    assign done_clr_p = ctrl_wr && reg_wdata[5];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q    <= '0;
            mode_byte  <= '0;
            addr_size  <= '0;
            start_addr <= '0;
            byte_count <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                RIDX_INSTR: instr_q    <= reg_wdata & INSTR_MASK;
                RIDX_MODEB: mode_byte  <= reg_wdata[7:0];
                RIDX_ASIZE: addr_size  <= reg_wdata[3:0];
                RIDX_SADDR: start_addr <= reg_wdata;
                RIDX_COUNT: byte_count <= reg_wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/qrd_fifo.sv
module qrd_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        push,
    input  logic [7:0]  push_data,
    input  logic        pop,
    output logic [7:0]  pop_data,
    output logic [AW:0] level,
    output logic        full
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full     = (level == (AW+1)'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && (level != '0);
    assign pop_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; level <= '0;
        end else if (clear) begin
            wp <= '0; rp <= '0; level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full) else $error("push into full FIFO"); // R9
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level == '0)) else $error("clear left data"); // R10
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && level == '0 && !push && !clear) |=> (level == '0)) else $error("pop on empty moved level"); // R11
endmodule

// File: rtl/qrd_seq.sv
module qrd_seq
    import qrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  opcode,
    input  logic [1:0]  data_lane,
    input  logic        mode_en,
    input  logic [4:0]  dummy_clks,
    input  logic [7:0]  mode_byte,
    input  logic [1:0]  addr_sz,
    input  logic [31:0] start_addr,
    input  logic [31:0] byte_count,
    input  logic        start_p,
    input  logic        cancel_p,
    input  logic        done_clr_p,
    input  logic        fifo_full,
    input  logic [3:0]  dq_in,
    output logic        busy,
    output logic        done,
    output logic        cs_n,
    output logic        sclk_en,
    output logic [3:0]  dq_out,
    output logic [3:0]  dq_oe,
    output logic        push,
    output logic [7:0]  push_data
);
    seq_state_e  state, state_d;
    logic [5:0]  cnt, cnt_d;
    logic [31:0] sh, sh_d;
    logic [7:0]  acc, acc_d, acc_next;
    logic [31:0] left, left_d;
    logic        done_d;
    logic [5:0]  per_byte_m1, addr_m1, after_hdr_cnt;
    logic [31:0] addr_aligned;
    seq_state_e  after_hdr;

    always_comb begin
        unique case (data_lane)
            LANE_QUAD: begin per_byte_m1 = 6'd1; acc_next = {acc[3:0], dq_in};      end
            LANE_DUAL: begin per_byte_m1 = 6'd3; acc_next = {acc[5:0], dq_in[1:0]}; end
            default:   begin per_byte_m1 = 6'd7; acc_next = {acc[6:0], dq_in[1]};   end
        endcase
        unique case (addr_sz)
            2'd0:    addr_aligned = {start_addr[7:0], 24'b0};
            2'd1:    addr_aligned = {start_addr[15:0], 16'b0};
            2'd2:    addr_aligned = {start_addr[23:0], 8'b0};
            default: addr_aligned = start_addr;
        endcase
        addr_m1 = {1'b0, addr_sz, 3'b111};
        if (dummy_clks != 5'd0) begin
            after_hdr     = S_DUMMY;
            after_hdr_cnt = {1'b0, dummy_clks} - 6'd1;
        end else begin
            after_hdr     = S_DATA;
            after_hdr_cnt = per_byte_m1;
        end
    end

    // next-state process
    always_comb begin
        state_d = state; cnt_d = cnt; sh_d = sh;
        acc_d = acc; left_d = left; done_d = done;
        if (done_clr_p) done_d = 1'b0;
        unique case (state)
            S_IDLE: if (start_p && !cancel_p && byte_count != '0) begin
                state_d = S_CMD; cnt_d = 6'd7;
                sh_d = {opcode, 24'b0}; left_d = byte_count; done_d = 1'b0;
            end
            S_CMD: begin
                sh_d = {sh[30:0], 1'b0};
                if (cnt == '0) begin
                    state_d = S_ADDR; cnt_d = addr_m1; sh_d = addr_aligned;
                end else cnt_d = cnt - 6'd1;
            end
            S_ADDR: begin
                sh_d = {sh[30:0], 1'b0};
                if (cnt == '0) begin
                    if (mode_en) begin
                        state_d = S_MODE; cnt_d = 6'd7; sh_d = {mode_byte, 24'b0};
                    end else begin
                        state_d = after_hdr; cnt_d = after_hdr_cnt;
                    end
                end else cnt_d = cnt - 6'd1;
            end
            S_MODE: begin
                sh_d = {sh[30:0], 1'b0};
                if (cnt == '0) begin
                    state_d = after_hdr; cnt_d = after_hdr_cnt;
                end else cnt_d = cnt - 6'd1;
            end
            S_DUMMY: begin
                if (cnt == '0) begin
                    state_d = S_DATA; cnt_d = per_byte_m1;
                end else cnt_d = cnt - 6'd1;
            end
            S_DATA: if (!fifo_full) begin
                acc_d = acc_next;
                if (cnt == '0) begin
                    left_d = left - 32'd1; cnt_d = per_byte_m1;
                    if (left == 32'd1) begin
                        state_d = S_IDLE; done_d = 1'b1;
                    end
                end else cnt_d = cnt - 6'd1;
            end
            default: state_d = S_IDLE;
        endcase
        if (cancel_p) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; cnt <= '0; sh <= '0;
            acc <= '0; left <= '0; done <= 1'b0;
        end else begin
            state <= state_d; cnt <= cnt_d; sh <= sh_d;
            acc <= acc_d; left <= left_d; done <= done_d;
        end
    end

    // output process
    always_comb begin
        busy      = (state != S_IDLE);
        cs_n      = (state == S_IDLE);
        sclk_en   = 1'b0;
        dq_oe     = 4'b0000;
        dq_out    = 4'b0000;
        push      = 1'b0;
        push_data = acc_next;
        unique case (state)
            S_CMD, S_ADDR, S_MODE: begin
                sclk_en = 1'b1; dq_oe = 4'b0001; dq_out = {3'b000, sh[31]};
            end
            S_DUMMY: sclk_en = 1'b1;
            S_DATA: begin
                sclk_en = !fifo_full;
                push    = !fifo_full && (cnt == '0);
            end
            default: ;
        endcase
    end

    AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_p |=> (state == S_IDLE)) else $error("cancel ignored"); // R10
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == S_DATA) && (state == S_IDLE)) else $error("done out of place"); // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && fifo_full && !cancel_p) |=> $stable(acc) && $stable(cnt) && $stable(left)) else $error("stall moved"); // R9
    AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && start_p && !cancel_p && left > 32'd1) |=> (state == S_DATA)) else $error("restart while busy"); // R7
endmodule

// File: rtl/qrd_top.sv
module qrd_top
    import qrd_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        fifo_pop,
    output logic [7:0]  fifo_data,
    output logic        fl_cs_n,
    output logic        fl_sclk_en,
    output logic [3:0]  fl_dq_out,
    output logic [3:0]  fl_dq_oe,
    input  logic [3:0]  fl_dq_in
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;

    logic [31:0] instr_q, start_addr, byte_count;
    logic [7:0]  mode_byte, push_data;
    logic [3:0]  addr_size;
    logic        start_p, cancel_p, done_clr_p;
    logic        busy, done, push, fifo_full;
    logic [LW-1:0] level;

    qrd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .instr_q(instr_q), .mode_byte(mode_byte),
        .addr_size(addr_size), .start_addr(start_addr), .byte_count(byte_count),
        .start_p(start_p), .cancel_p(cancel_p), .done_clr_p(done_clr_p)
    );

    qrd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .opcode(instr_q[7:0]), .data_lane(instr_q[17:16]),
        .mode_en(instr_q[20]), .dummy_clks(instr_q[28:24]), .mode_byte(mode_byte),
        .addr_sz(addr_size[1:0]), .start_addr(start_addr), .byte_count(byte_count),
        .start_p(start_p), .cancel_p(cancel_p), .done_clr_p(done_clr_p),
        .fifo_full(fifo_full), .dq_in(fl_dq_in), .busy(busy), .done(done),
        .cs_n(fl_cs_n), .sclk_en(fl_sclk_en), .dq_out(fl_dq_out), .dq_oe(fl_dq_oe),
        .push(push), .push_data(push_data)
    );

    qrd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(cancel_p), .push(push),
        .push_data(push_data), .pop(fifo_pop), .pop_data(fifo_data),
        .level(level), .full(fifo_full)
    );

    always_comb begin
        unique case (reg_addr)
            RIDX_INSTR: reg_rdata = instr_q;
            RIDX_MODEB: reg_rdata = {24'b0, mode_byte};
            RIDX_ASIZE: reg_rdata = {28'b0, addr_size};
            RIDX_SADDR: reg_rdata = start_addr;
            RIDX_COUNT: reg_rdata = byte_count;
            RIDX_CTRL:  reg_rdata = {26'b0, done, 2'b0, busy, 2'b0};
            RIDX_LEVEL: reg_rdata = {16'b0, 16'(level)};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/qrd_top_bench.sv
module qrd_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam logic [2:0] A_INSTR = 3'd0, A_MODEB = 3'd1, A_ASIZE = 3'd2,
                           A_SADDR = 3'd3, A_COUNT = 3'd4, A_CTRL = 3'd5, A_LEVEL = 3'd6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic fifo_pop = 1'b0;
    logic [7:0] fifo_data;
    logic fl_cs_n, fl_sclk_en;
    logic [3:0] fl_dq_out, fl_dq_oe;
    logic [3:0] fl_dq_in = 4'd0;

    int tests = 0, fails = 0, cyc = 0;
    int fl_n = 0, hdr_err = 0, oe_err = 0;
    int m_nab = 3, m_dummy = 0;
    logic m_mode = 1'b0;
    logic [1:0] m_lane = 2'd0;
    logic [7:0] m_op = '0, m_modeb = '0;
    logic [31:0] m_addr = '0;

    qrd_top #(.FIFO_DEPTH(DEPTH)) u_qrd_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_pop(fifo_pop),
        .fifo_data(fifo_data), .fl_cs_n(fl_cs_n), .fl_sclk_en(fl_sclk_en),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic hdr_bit(input int k);
        if (k < 8) return m_op[7-k];
        if (k < 8 + 8*m_nab) return m_addr[8*m_nab - 1 - (k-8)];
        return m_modeb[7 - (k - 8 - 8*m_nab)];
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash device model: drives DQ at the falling edge before each clocked cycle
    always @(negedge clk) begin
        if (fl_cs_n) fl_n = 0;
        else if (fl_sclk_en) begin
            int hb, h;
            hb = 8 + 8*m_nab + (m_mode ? 8 : 0);
            h  = hb + m_dummy;
            if (fl_n < hb) begin
                if (fl_dq_oe !== 4'b0001 || fl_dq_out[0] !== hdr_bit(fl_n)) hdr_err++;
            end else if (fl_n < h) begin
                if (fl_dq_oe !== 4'b0000) oe_err++;
            end else begin
                int d, bpc, cpb, j, p;
                logic [7:0] v;
                logic [31:0] r;
                if (fl_dq_oe !== 4'b0000) oe_err++;
                bpc = (m_lane == 2'd2) ? 4 : (m_lane == 2'd1) ? 2 : 1;
                cpb = 8 / bpc;
                d = fl_n - h; j = d / cpb; p = d % cpb;
                v = pat(m_addr + 32'(j));
                r = $urandom;
                fl_dq_in = r[3:0];
                if (bpc == 4) fl_dq_in = (p == 0) ? v[7:4] : v[3:0];
                else if (bpc == 2) fl_dq_in[1:0] = v[7-2*p -: 2];
                else fl_dq_in[1] = v[7-p];
            end
            fl_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic setup(input logic [7:0] op, input logic [1:0] lane, input logic [1:0] ilane,
                         input logic [1:0] alane, input logic mode, input logic [7:0] modeb,
                         input logic [4:0] dummy, input logic [1:0] asz,
                         input logic [31:0] addr, input logic [31:0] count);
        m_op = op; m_lane = lane; m_mode = mode; m_modeb = modeb;
        m_dummy = int'(dummy); m_nab = int'(asz) + 1; m_addr = addr;
        wr(A_INSTR, {3'b0, dummy, 3'b0, mode, 2'b0, lane, 2'b0, alane, 2'b0, ilane, op});
        wr(A_MODEB, {24'b0, modeb});
        wr(A_ASIZE, {30'b0, asz});
        wr(A_SADDR, addr);
        wr(A_COUNT, count);
        hdr_err = 0; oe_err = 0;
    endtask

    // gap: 0 pop always, 1 random pops, 2 hold pops to force a stall
    task automatic drain(input int count, input int gap);
        int k = 0, guard = 0, derr = 0, ovl = 0;
        logic [31:0] c, lv;
        logic [7:0] bad_act = '0, bad_exp = '0;
        bit allow;
        while (k < count && guard < 20000) begin
            @(negedge clk); #1;
            rd(A_CTRL, c); rd(A_LEVEL, lv);
            if (c[2] && c[5]) ovl++;
            if (gap == 2 && guard == 300) begin
                chk(lv == DEPTH, "R9 stalled level full", lv, DEPTH);
                chk(fl_sclk_en == 1'b0, "R9 no clock while full", 32'(fl_sclk_en), 0);
                chk(c[2] == 1'b1, "R9 still in progress", c, 32'h4);
            end
            allow = (gap == 0) || (gap == 1 && ($urandom % 3) != 0) || (gap == 2 && guard > 300);
            if (lv != 0 && allow) begin
                if (fifo_data !== pat(m_addr + 32'(k))) begin
                    if (derr == 0) begin bad_act = fifo_data; bad_exp = pat(m_addr + 32'(k)); end
                    derr++;
                end
                k++;
                fifo_pop = 1'b1;
            end else fifo_pop = 1'b0;
            guard++;
        end
        @(negedge clk); fifo_pop = 1'b0; #1;
        rd(A_CTRL, c);
        chk(k == count, "R7 bytes delivered", k, count);
        chk(derr == 0, "R6 data bytes", bad_act, bad_exp);
        chk(hdr_err == 0, "R3 R4 R5 header bits on DQ0", hdr_err, 0);
        chk(oe_err == 0, "R5 lanes released in dummy and data", oe_err, 0);
        chk(ovl == 0, "R8 done never with in-progress", ovl, 0);
        chk(c[2] == 1'b0 && c[5] == 1'b1, "R8 done after last byte", c, 32'h20);
        wr(A_CTRL, 32'h20);
        @(negedge clk); #1; rd(A_CTRL, c);
        chk(c == 32'h0, "R8 done cleared by write 1", c, 0);
    endtask

    initial begin
        logic [31:0] c, lv;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        rd(A_CTRL, c);  chk(c == 0, "R1 control after reset", c, 0);
        rd(A_LEVEL, lv); chk(lv == 0, "R1 level after reset", lv, 0);
        chk({fl_cs_n, fl_sclk_en, fl_dq_oe} == 6'b100000, "R1 pins idle", {fl_cs_n, fl_sclk_en, fl_dq_oe}, 6'b100000);

        // R2 field readback
        wr(A_INSTR, 32'hFFFF_FFFF);
        @(negedge clk); #1; rd(A_INSTR, c);
        chk(c == 32'h1F13_33FF, "R2 instruction word fields", c, 32'h1F13_33FF);

        // R7 start with zero count ignored
        setup(8'h0B, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 5'd8, 2'd2, 32'h0012_3456, 32'd0);
        wr(A_CTRL, 32'h1);
        @(negedge clk); #1; rd(A_CTRL, c);
        chk(c[2] == 1'b0 && fl_cs_n, "R7 zero count start ignored", c, 0);

        // directed: single, 3-byte address, 8 dummies
        setup(8'h0B, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 5'd8, 2'd2, 32'h0012_3456, 32'd5);
        wr(A_CTRL, 32'h1); drain(5, 0);
        // directed: quad with mode byte, zero dummies, 4-byte address, quad cmd lane field
        setup(8'hEC, 2'd2, 2'd2, 2'd2, 1'b1, 8'hA5, 5'd0, 2'd3, 32'hDEAD_BEEF, 32'd9);
        wr(A_CTRL, 32'h1); drain(9, 0);
        // directed: dual, one byte
        setup(8'h3B, 2'd1, 2'd0, 2'd0, 1'b0, 8'h00, 5'd31, 2'd2, 32'h00AB_CDEF, 32'd1);
        wr(A_CTRL, 32'h1); drain(1, 0);
        // directed: reserved lane code acts as single
        setup(8'h03, 2'd3, 2'd0, 2'd0, 1'b0, 8'h00, 5'd0, 2'd0, 32'h0000_0077, 32'd3);
        wr(A_CTRL, 32'h1); drain(3, 0);
        // R9 stall: quad, 24 bytes, no pops until FIFO fills
        setup(8'h6B, 2'd2, 2'd0, 2'd0, 1'b0, 8'h00, 5'd4, 2'd2, 32'h0000_1000, 32'd24);
        wr(A_CTRL, 32'h1); drain(24, 2);
        // R7 start while busy ignored, count latched
        setup(8'h0B, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 5'd8, 2'd2, 32'h0000_2000, 32'd5);
        wr(A_CTRL, 32'h1);
        wr(A_COUNT, 32'd3);
        wr(A_CTRL, 32'h1);
        drain(5, 0);

        // R10 cancel mid-transfer
        setup(8'h0B, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 5'd0, 2'd2, 32'h0000_3000, 32'd30);
        wr(A_CTRL, 32'h1);
        repeat (60) @(negedge clk);
        #1; rd(A_LEVEL, lv);
        chk(lv != 0, "R11 level counts pushed bytes", lv, 3);
        wr(A_CTRL, 32'h2);
        @(negedge clk); #1;
        rd(A_CTRL, c);  chk(c == 0, "R10 cancel clears in-progress, no done", c, 0);
        rd(A_LEVEL, lv); chk(lv == 0, "R10 cancel empties FIFO", lv, 0);
        chk(fl_cs_n == 1'b1, "R10 chip select high after cancel", 32'(fl_cs_n), 1);
        // R10 cancel wins over start
        wr(A_CTRL, 32'h3);
        @(negedge clk); #1; rd(A_CTRL, c);
        chk(c == 0 && fl_cs_n, "R10 cancel beats start", c, 0);

        // R11 pop on empty
        @(negedge clk); fifo_pop = 1'b1;
        @(negedge clk); fifo_pop = 1'b0; #1;
        rd(A_LEVEL, lv); chk(lv == 0, "R11 pop on empty ignored", lv, 0);

        // random transfers
        for (int t = 0; t < 14; t++) begin
            logic [31:0] r1, r2, r3;
            int cnt;
            r1 = $urandom; r2 = $urandom; r3 = $urandom;
            cnt = 1 + int'(r3 % 40);
            setup(r1[7:0], r1[9:8], r1[11:10], r1[13:12], r1[14], r1[23:16], r1[28:24],
                  r1[31:30], r2, 32'(cnt));
            wr(A_CTRL, 32'h1);
            drain(cnt, 1);
        end

        summary();
        $finish;
    end
endmodule